// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Coherent Byte Reads

This block holds a 16-bit up counter that advances once per tick of a programmable prescaler. The counter cannot be written, and it wraps around when it passes its top value. An 8-bit processor reads the count as two bytes at adjacent addresses.

Reading the upper byte copies the lower byte into a holding register. A lower-byte read in the very next cycle then returns that copy. Software therefore gets one consistent 16-bit value, even when a carry between the two bytes happens between the two reads.

The division ratio is taken from a 2-bit pin while reset is held and stays fixed after that. A one-cycle strobe marks each wrap of the counter.

Top module: `tcnt_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the count is zero and `rdata` and `ovf` are low; the first upper/lower read after reset returns 0x0000.
- R2: The count goes up by exactly one on each prescaler tick and holds its value on all other cycles.
- R3: `presc_sel` is sampled only while `rst` is high. The codes are 0 for divide-by-1, 1 for divide-by-4, 2 for divide-by-8 and 3 for divide-by-16. After release the count equals floor(edges since release / divisor). A change of `presc_sel` outside reset has no effect.
- R4: A read (`cs` and `rd` high) at `CNT_ADDR` (default 0xE) returns count bits 15:8 on `rdata` in the cycle after the strobe cycle.
- R5: A read at `CNT_ADDR`+1 in the cycle right after an upper-byte read returns the count's bits 7:0 as they stood when the upper byte was read, even if the live value has since carried.
- R6: A read at `CNT_ADDR`+1 that does not directly follow an upper-byte read returns the live bits 7:0.
- R7: Write strobes (`wr`) to either counter address, with any `wdata`, leave the count unchanged.
- R8: After 0xFFFF the count becomes 0x0000, and `ovf` is high for exactly the one cycle in which the count first reads zero.
- R9: `rdata` is zero in the cycle after any cycle without a selected read, or with a read at an address that is neither counter byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; also loads the prescaler code |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (no effect on this block) |
| addr | input | 4 | Byte address |
| wdata | input | 8 | Write data (no effect on this block) |
| presc_sel | input | 2 | Prescaler code, sampled during reset |
| rdata | output | 8 | Registered read data |
| ovf | output | 1 | One-cycle wrap strobe |

## Verification
Some properties are checked by assertions on every cycle:
- the count holds between ticks and steps by one on a tick;
- the prescaler code stays frozen after reset;
- ticks never come back to back at a ratio above one;
- the wrap strobe lasts one cycle and coincides with a zero count;
- idle cycles return zero data;
- a buffered lower-byte read returns the held byte.

The absolute count after a given number of edges for each division ratio can only be shown by the bench's scenarios. The same holds for snapshot coherence across a carry from 0x00FF, the live lower-byte result after a gap, and the absence of any effect from writes and from late changes of `presc_sel`.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

  typedef enum logic [1:0] {
    DIV1  = 2'd0,
    DIV4  = 2'd1,
    DIV8  = 2'd2,
    DIV16 = 2'd3
  } presc_e;

  // terminal value of the prescaler counter for each ratio
  function automatic logic [3:0] presc_limit(presc_e s);
    case (s)
      DIV1:    return 4'd0;
      DIV4:    return 4'd3;
      DIV8:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/tcnt_prescaler.sv
module tcnt_prescaler
  import tcnt_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  presc_e sel_i,
  output logic   ce_o
);

  presc_e             cfg_q;
  logic [PRE_W-1:0]   pcnt_q;
  logic [PRE_W-1:0]   limit;

  assign limit = PRE_W'(presc_limit(cfg_q));
  assign ce_o  = (pcnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= sel_i;
      pcnt_q <= '0;
    end else if (pcnt_q == limit) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg_q)); // R3
  AST_CE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (ce_o && cfg_q != DIV1) |=> !ce_o); // R3

endmodule

// File: rtl/tcnt_counter.sv
module tcnt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_top;

  assign at_top = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ce_i && at_top;
      if (ce_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ce_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> cnt_q == '0); // R8
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q); // R8

endmodule

// File: rtl/tcnt_readport.sv
module tcnt_readport #(
  parameter int                BUS_W    = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [2*BUS_W-1:0]   cnt_i,
  output logic [BUS_W-1:0]     rdata_o
);

  localparam logic [ADDR_W-1:0] LO_ADDR = BASE_ADDR + 1'b1;

  logic             hit_hi, hit_lo;
  logic [BUS_W-1:0] lo_buf_q;
  logic             buf_vld_q;
  logic [BUS_W-1:0] rdata_q;

  assign hit_hi = cs_i && rd_i && (addr_i == BASE_ADDR);
  assign hit_lo = cs_i && rd_i && (addr_i == LO_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_buf_q  <= '0;
      buf_vld_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      buf_vld_q <= hit_hi;
      if (hit_hi) lo_buf_q <= cnt_i[BUS_W-1:0];
      if (hit_hi)
        rdata_q <= cnt_i[2*BUS_W-1:BUS_W];
      else if (hit_lo)
        rdata_q <= buf_vld_q ? lo_buf_q : cnt_i[BUS_W-1:0];
      else
        rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(cs_i && rd_i) |=> rdata_q == '0); // R9
  AST_LO_BUFFERED: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && buf_vld_q) |=> rdata_q == $past(lo_buf_q)); // R5

endmodule

// File: rtl/tcnt_timer.sv
module tcnt_timer
  import tcnt_pkg::*;
#(
  parameter int                BUS_W    = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 4'hE,
  parameter int                PRE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [1:0]        presc_sel,
  output logic [BUS_W-1:0]  rdata,
  output logic              ovf
);

  localparam int CNT_W = 2 * BUS_W;

  logic             ce;
  logic [CNT_W-1:0] cnt;
  logic             unused_wr_bits;

  // the count is read-only: write strobe and data go nowhere
  assign unused_wr_bits = wr ^ (^wdata);

  tcnt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .sel_i (presc_e'(presc_sel)),
    .ce_o  (ce)
  );

  tcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ce_i  (ce),
    .cnt_o (cnt),
    .ovf_o (ovf)
  );

  tcnt_readport #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(CNT_ADDR)) u_rp (
    .clk     (clk),
    .rst     (rst),
    .cs_i    (cs),
    .rd_i    (rd),
    .addr_i  (addr),
    .cnt_i   (cnt),
    .rdata_o (rdata)
  );

endmodule

// File: tb/tcnt_timer_tb.sv
module tcnt_timer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [1:0] presc_sel = 2'd0;
  logic [7:0] rdata;
  logic       ovf;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  tcnt_timer u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .presc_sel(presc_sel), .rdata(rdata), .ovf(ovf)
  );

  // {sel, edges waited after release, expected 16-bit snapshot}
  localparam int NV = 11;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'd0,    16'h0000},
    {2'd0, 16'd5,    16'h0005},
    {2'd1, 16'd10,   16'h0002},
    {2'd2, 16'd100,  16'h000C},
    {2'd3, 16'd1000, 16'h003E},
    {2'd0, 16'd300,  16'h012C},
    {2'd1, 16'd1023, 16'h00FF},
    {2'd3, 16'd16,   16'h0001},
    {2'd2, 16'd7,    16'h0000},
    {2'd0, 16'd255,  16'h00FF},
    {2'd0, 16'd511,  16'h01FF}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; presc_sel = sel;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_pair(output logic [15:0] val);
    cs = 1'b1; rd = 1'b1; addr = 4'hE;
    @(negedge clk);
    val[15:8] = rdata;
    addr = 4'hF;
    @(negedge clk);
    val[7:0] = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic read_one(input logic [3:0] a, input logic c, output logic [7:0] v);
    cs = c; rd = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v16;
    logic [7:0]  v8;

    // R1: outputs quiet during reset, even with a read strobe present
    presc_sel = 2'd0;
    cs = 1'b1; rd = 1'b1; addr = 4'hE;
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", {8'h00, rdata}, 16'h0000);
    check("R1 ovf in reset", {15'd0, ovf}, 16'h0000);
    cs = 1'b0; rd = 1'b0;

    // R1 R3 R4 R5: vector walk over ratios and carry points
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][33:32]);
      repeat (int'(VEC[i][31:16])) @(negedge clk);
      read_pair(v16);
      check($sformatf("R4 R5 R3 vec %0d", i), v16, VEC[i][15:0]);
    end

    // R6: lower byte read with a gap after the upper read is live
    do_reset(2'd0);
    repeat (10) @(negedge clk);
    read_one(4'hE, 1'b1, v8);
    check("R4 hi before gap", {8'h00, v8}, 16'h0000);
    @(negedge clk);
    read_one(4'hF, 1'b1, v8);
    check("R6 live lo after gap", {8'h00, v8}, 16'h000C);

    // R6: lower byte read with no upper read at all
    do_reset(2'd0);
    repeat (40) @(negedge clk);
    read_one(4'hF, 1'b1, v8);
    check("R6 live lo alone", {8'h00, v8}, 16'h0028);

    // R9: unmatched address and deselected read give zero
    read_one(4'h3, 1'b1, v8);
    check("R9 other addr", {8'h00, v8}, 16'h0000);
    read_one(4'hE, 1'b0, v8);
    check("R9 cs low", {8'h00, v8}, 16'h0000);

    // R7: writes to both counter addresses leave the count alone
    do_reset(2'd0);
    repeat (20) @(negedge clk);
    cs = 1'b1; wr = 1'b1; wdata = 8'hFF; addr = 4'hE;
    @(negedge clk);
    addr = 4'hF; wdata = 8'h55;
    @(negedge clk);
    check("R7 R9 rdata after write", {8'h00, rdata}, 16'h0000);
    cs = 1'b0; wr = 1'b0;
    read_pair(v16);
    check("R7 count after writes", v16, 16'h0016);

    // R3: late change of presc_sel is ignored
    do_reset(2'd3);
    presc_sel = 2'd0;
    repeat (64) @(negedge clk);
    read_pair(v16);
    check("R3 sel change ignored", v16, 16'h0004);

    // R8: wrap and one-cycle overflow strobe at divide-by-1
    do_reset(2'd0);
    repeat (65535) @(negedge clk);
    check("R8 ovf before wrap", {15'd0, ovf}, 16'h0000);
    @(negedge clk);
    check("R8 ovf at wrap", {15'd0, ovf}, 16'h0001);
    @(negedge clk);
    check("R8 ovf after wrap", {15'd0, ovf}, 16'h0000);
    read_pair(v16);
    check("R8 R2 count after wrap", v16, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule